// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers interrupt requests in two chained latch-and-mask stages and drives one interrupt output. The front stage captures serial interrupt lines and error sources into a sticky status word. Its masked, enable-gated result feeds one bit of the back stage's read-only input word. The back stage latches its masked input into a second sticky status word, and the interrupt output is high while that word holds any set bit. Software reaches every register through a single 32-bit word port with byte offsets. Both status words are cleared by writing ones.

A mode input selects an alternative level-tracking path. In that path the lower sixteen serial lines are sampled each clock into a vector without latching, and a separate output is high while any sampled line is high. Both stages are evaluated on every clock, not only on register writes. When hardware sets a status bit in the same cycle that software clears it, the bit stays set.

Top module: `irq_chain_agg`

## Requirements
- R1: With `lvl_mode` low, a high level on `ser_in[n]` at a clock edge sets front status bit (31 - n) at offset 0x38. A low level never clears it.
- R2: Writing offset 0x38 clears each bit written as 1. If hardware sets a bit in the same cycle, that bit stays set.
- R3: The front result is high only when bit 31 of the control word at 0x30 is set and (status AND mask at 0x34) is non-zero. One clock later it appears as bit 11 of the back input word at 0x5C, and every other bit of that word reads 0.
- R4: Each clock, the back status word at 0x50 ORs in (input word AND mask at 0x54). Writing 0x50 clears the bits written as 1, and a bit set by hardware in the same cycle stays set.
- R5: `irq_out` is high exactly while the back status word is non-zero.
- R6: Offsets 0x5C and 0x40 are read-only and ignore writes. Offset 0x40 always reads 0.
- R7: The words at 0x08, 0x0C, 0x28, 0x30, 0x34, 0x54 and 0x58 store the full written value and read it back. The words at 0x08, 0x0C and 0x58 do not affect any output.
- R8: A read of any other offset, including one not aligned to 4 bytes, returns 0xFFFFFFFF. A write to such an offset changes nothing.
- R9: After reset every register reads 0, except 0x28, which reads 0x02000000. `irq_out` and `ext_irq_out` are low.
- R10: A high level on `err_in[e]` at a clock edge sets front status bit e, in either mode.
- R11: With `lvl_mode` high, `lvl_vec` takes `ser_in[15:0]` at each clock edge and `ext_irq_out` is high while `lvl_vec` is non-zero. The serial lines then set no front status bits. With `lvl_mode` low, `lvl_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_mode | input | 1 | Selects level tracking instead of latching for serial lines |
| ser_in | input | 17 | Serial interrupt request levels |
| err_in | input | 8 | Error source levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Read data word for `addr`, combinational, no side effects |
| irq_out | output | 1 | Aggregated interrupt from back status |
| ext_irq_out | output | 1 | Any tracked level high |
| lvl_vec | output | 16 | Tracked serial levels in level mode |

## Verification
The assertions assume that `ser_in`, `err_in`, `lvl_mode` and the write controls are stable around each rising edge. They also assume that a write happens in at most one register per cycle, which follows from the single address port. The bench changes every input on the falling edge only. It draws addresses from the implemented offsets mixed with unimplemented and unaligned ones, and it keeps serial and error pulses sparse so that both the sticky and the cleared states are exercised.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] OFF_ROUTE_A = 8'h08;
  localparam logic [AW-1:0] OFF_ROUTE_B = 8'h0C;
  localparam logic [AW-1:0] OFF_RDSZ    = 8'h28;
  localparam logic [AW-1:0] OFF_SCTL    = 8'h30;
  localparam logic [AW-1:0] OFF_HMASK   = 8'h34;
  localparam logic [AW-1:0] OFF_HSTAT   = 8'h38;
  localparam logic [AW-1:0] OFF_ERRAD   = 8'h40;
  localparam logic [AW-1:0] OFF_RSTAT   = 8'h50;
  localparam logic [AW-1:0] OFF_RMASK   = 8'h54;
  localparam logic [AW-1:0] OFF_RPOL    = 8'h58;
  localparam logic [AW-1:0] OFF_RIN     = 8'h5C;

  localparam logic [DW-1:0] RDSZ_RESET = 32'h0200_0000;
  localparam int EN_BIT   = 31;
  localparam int LINK_BIT = 11;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ROUTE_A, SEL_ROUTE_B, SEL_RDSZ, SEL_SCTL, SEL_HMASK,
    SEL_HSTAT, SEL_ERRAD, SEL_RSTAT, SEL_RMASK, SEL_RPOL, SEL_RIN
  } sel_e;
endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
(
  input  logic [AW-1:0] addr,
  output sel_e          sel
);
  always_comb begin
    unique case (addr)
      OFF_ROUTE_A: sel = SEL_ROUTE_A;
      OFF_ROUTE_B: sel = SEL_ROUTE_B;
      OFF_RDSZ:    sel = SEL_RDSZ;
      OFF_SCTL:    sel = SEL_SCTL;
      OFF_HMASK:   sel = SEL_HMASK;
      OFF_HSTAT:   sel = SEL_HSTAT;
      OFF_ERRAD:   sel = SEL_ERRAD;
      OFF_RSTAT:   sel = SEL_RSTAT;
      OFF_RMASK:   sel = SEL_RMASK;
      OFF_RPOL:    sel = SEL_RPOL;
      OFF_RIN:     sel = SEL_RIN;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqagg_hc_stage.sv
module irqagg_hc_stage
  import irqagg_pkg::*;
#(
  parameter int N_SER = 17,
  parameter int N_ERR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_mode,
  input  logic [N_SER-1:0] ser_in,
  input  logic [N_ERR-1:0] err_in,
  input  logic             we_sctl,
  input  logic             we_hmask,
  input  logic             we_hstat,
  input  logic             we_rdsz,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    sctl_q,
  output logic [DW-1:0]    hmask_q,
  output logic [DW-1:0]    hstat_q,
  output logic [DW-1:0]    rdsz_q,
  output logic             hc_res
);
  // serial line n lands on bit DW-1-n, error e on bit e; N_SER+N_ERR must not exceed DW
  logic [DW-1:0] hw_set;
  logic [DW-1:0] sw_clr;
  logic [DW-1:0] hstat_d, sctl_d, hmask_d, rdsz_d;

  always_comb begin
    hw_set = '0;
    for (int n = 0; n < N_SER; n++) hw_set[DW-1-n] = ser_in[n] & ~lvl_mode;
    for (int e = 0; e < N_ERR; e++) hw_set[e] = hw_set[e] | err_in[e];
  end

  always_comb begin
    sw_clr  = we_hstat ? wdata : '0;
    hstat_d = (hstat_q & ~sw_clr) | hw_set;
    sctl_d  = we_sctl  ? wdata : sctl_q;
    hmask_d = we_hmask ? wdata : hmask_q;
    rdsz_d  = we_rdsz  ? wdata : rdsz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hstat_q <= '0;
      sctl_q  <= '0;
      hmask_q <= '0;
      rdsz_q  <= RDSZ_RESET;
    end else begin
      hstat_q <= hstat_d;
      sctl_q  <= sctl_d;
      hmask_q <= hmask_d;
      rdsz_q  <= rdsz_d;
    end
  end

  assign hc_res = sctl_q[EN_BIT] & (|(hstat_q & hmask_q));
endmodule

// File: rtl/irqagg_relay_stage.sv
module irqagg_relay_stage
  import irqagg_pkg::*;
#(
  parameter int LINK = LINK_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hc_res,
  input  logic          we_rstat,
  input  logic          we_rmask,
  input  logic          we_rpol,
  input  logic          we_ra,
  input  logic          we_rb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rin_q,
  output logic [DW-1:0] rstat_q,
  output logic [DW-1:0] rmask_q,
  output logic [DW-1:0] rpol_q,
  output logic [DW-1:0] ra_q,
  output logic [DW-1:0] rb_q,
  output logic          irq_out
);
  logic [DW-1:0] rin_d, rstat_d, rmask_d, rpol_d, ra_d, rb_d, sw_clr;

  always_comb begin
    rin_d       = '0;
    rin_d[LINK] = hc_res;
    sw_clr      = we_rstat ? wdata : '0;
    rstat_d     = (rstat_q & ~sw_clr) | (rin_q & rmask_q);
    rmask_d     = we_rmask ? wdata : rmask_q;
    rpol_d      = we_rpol  ? wdata : rpol_q;
    ra_d        = we_ra    ? wdata : ra_q;
    rb_d        = we_rb    ? wdata : rb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rin_q   <= '0;
      rstat_q <= '0;
      rmask_q <= '0;
      rpol_q  <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
    end else begin
      rin_q   <= rin_d;
      rstat_q <= rstat_d;
      rmask_q <= rmask_d;
      rpol_q  <= rpol_d;
      ra_q    <= ra_d;
      rb_q    <= rb_d;
    end
  end

  assign irq_out = |rstat_q;
endmodule

// File: rtl/irqagg_level_track.sv
module irqagg_level_track #(
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_mode,
  input  logic [N_LVL-1:0] lines,
  output logic [N_LVL-1:0] lvl_q,
  output logic             any_hi
);
  logic [N_LVL-1:0] lvl_d;

  always_comb lvl_d = lvl_mode ? lines : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign any_hi = |lvl_q;
endmodule

// File: rtl/irq_chain_agg.sv
module irq_chain_agg
  import irqagg_pkg::*;
#(
  parameter int N_SER = 17,
  parameter int N_ERR = 8,
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_mode,
  input  logic [N_SER-1:0] ser_in,
  input  logic [N_ERR-1:0] err_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_out,
  output logic             ext_irq_out,
  output logic [N_LVL-1:0] lvl_vec
);
  sel_e sel;
  logic [DW-1:0] sctl_q, hmask_q, hstat_q, rdsz_q;
  logic [DW-1:0] rin_q, rstat_q, rmask_q, rpol_q, ra_q, rb_q;
  logic hc_res;

  irqagg_decode u_dec (.addr(addr), .sel(sel));

  irqagg_hc_stage #(.N_SER(N_SER), .N_ERR(N_ERR)) u_hc (
    .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode), .ser_in(ser_in), .err_in(err_in),
    .we_sctl(wr_en && sel == SEL_SCTL), .we_hmask(wr_en && sel == SEL_HMASK),
    .we_hstat(wr_en && sel == SEL_HSTAT), .we_rdsz(wr_en && sel == SEL_RDSZ),
    .wdata(wdata), .sctl_q(sctl_q), .hmask_q(hmask_q), .hstat_q(hstat_q),
    .rdsz_q(rdsz_q), .hc_res(hc_res)
  );

  irqagg_relay_stage #(.LINK(LINK_BIT)) u_relay (
    .clk(clk), .rst_n(rst_n), .hc_res(hc_res),
    .we_rstat(wr_en && sel == SEL_RSTAT), .we_rmask(wr_en && sel == SEL_RMASK),
    .we_rpol(wr_en && sel == SEL_RPOL), .we_ra(wr_en && sel == SEL_ROUTE_A),
    .we_rb(wr_en && sel == SEL_ROUTE_B), .wdata(wdata),
    .rin_q(rin_q), .rstat_q(rstat_q), .rmask_q(rmask_q), .rpol_q(rpol_q),
    .ra_q(ra_q), .rb_q(rb_q), .irq_out(irq_out)
  );

  irqagg_level_track #(.N_LVL(N_LVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode), .lines(ser_in[N_LVL-1:0]),
    .lvl_q(lvl_vec), .any_hi(ext_irq_out)
  );

  always_comb begin
    unique case (sel)
      SEL_ROUTE_A: rdata = ra_q;
      SEL_ROUTE_B: rdata = rb_q;
      SEL_RDSZ:    rdata = rdsz_q;
      SEL_SCTL:    rdata = sctl_q;
      SEL_HMASK:   rdata = hmask_q;
      SEL_HSTAT:   rdata = hstat_q;
      SEL_ERRAD:   rdata = '0;
      SEL_RSTAT:   rdata = rstat_q;
      SEL_RMASK:   rdata = rmask_q;
      SEL_RPOL:    rdata = rpol_q;
      SEL_RIN:     rdata = rin_q;
      default:     rdata = '1;
    endcase
  end
endmodule

// File: rtl/irq_chain_agg_chk.sv
module irq_chain_agg_chk
  import irqagg_pkg::*;
#(
  parameter int N_SER = 17,
  parameter int N_LVL = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lvl_mode,
  input logic [N_SER-1:0] ser_in,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    hstat,
  input logic             hc_res,
  input logic [DW-1:0]    link_in,
  input logic [DW-1:0]    mask2,
  input logic [DW-1:0]    stat2,
  input logic             irq_out,
  input logic             ext_irq_out
);
  a_r1_ser_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && ser_in[0]) |=> hstat[DW-1]);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hstat[DW-1] && !(wr_en && addr == OFF_HSTAT && wdata[DW-1])) |=> hstat[DW-1]);

  a_r3_link_up: assert property (@(posedge clk) disable iff (!rst_n)
    hc_res |=> link_in[LINK_BIT]);

  a_r3_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_res |=> !link_in[LINK_BIT]);

  a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in[LINK_BIT] && mask2[LINK_BIT]) |=> stat2[LINK_BIT]);

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|(link_in & mask2)));

  a_r11_ext_on: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && |ser_in[N_LVL-1:0]) |=> ext_irq_out);

  a_r11_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_mode |=> !ext_irq_out);
endmodule

bind irq_chain_agg irq_chain_agg_chk #(.N_SER(N_SER), .N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode), .ser_in(ser_in),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .hstat(hstat_q), .hc_res(hc_res),
  .link_in(rin_q), .mask2(rmask_q), .stat2(rstat_q), .irq_out(irq_out),
  .ext_irq_out(ext_irq_out)
);

// File: tb/irq_chain_agg_bench.sv
module irq_chain_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvl_mode = 1'b0;
  logic [16:0] ser_in = '0;
  logic [7:0]  err_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out, ext_irq_out;
  logic [15:0] lvl_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_chain_agg u_irq_chain_agg (
    .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode), .ser_in(ser_in), .err_in(err_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
    .ext_irq_out(ext_irq_out), .lvl_vec(lvl_vec)
  );

  // expected state, built from the requirements
  logic [31:0] m_ra, m_rb, m_rdsz, m_sctl, m_hmask, m_hstat, m_rin, m_rstat, m_rmask, m_rpol;
  logic [15:0] m_lvl;

  function automatic logic [31:0] serial_bits(logic [16:0] s, logic lm);
    logic [31:0] v = '0;
    for (int n = 0; n < 17; n++) v[31-n] = s[n] & ~lm;
    return v;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h08: return m_ra;     8'h0C: return m_rb;
      8'h28: return m_rdsz;   8'h30: return m_sctl;
      8'h34: return m_hmask;  8'h38: return m_hstat;
      8'h40: return 32'h0;    8'h50: return m_rstat;
      8'h54: return m_rmask;  8'h58: return m_rpol;
      8'h5C: return m_rin;    default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] a);
    case (a)
      8'h38: return "R1";  8'h5C: return "R3";  8'h50: return "R4";
      8'h40: return "R6";  8'h08, 8'h0C, 8'h28, 8'h30, 8'h34, 8'h54, 8'h58: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ra = '0; m_rb = '0; m_rdsz = 32'h0200_0000; m_sctl = '0; m_hmask = '0;
      m_hstat = '0; m_rin = '0; m_rstat = '0; m_rmask = '0; m_rpol = '0; m_lvl = '0;
    end else begin
      logic [31:0] clr1, clr2, nin;
      logic res;
      clr1 = (wr_en && addr == 8'h38) ? wdata : '0;
      clr2 = (wr_en && addr == 8'h50) ? wdata : '0;
      res  = m_sctl[31] && ((m_hstat & m_hmask) != 0);
      nin  = res ? 32'h0000_0800 : 32'h0;
      m_rstat = (m_rstat & ~clr2) | (m_rin & m_rmask);
      m_rin   = nin;
      m_hstat = (m_hstat & ~clr1) | serial_bits(ser_in, lvl_mode) | {24'h0, err_in};
      m_lvl   = lvl_mode ? ser_in[15:0] : 16'h0;
      if (wr_en) begin
        case (addr)
          8'h08: m_ra = wdata;    8'h0C: m_rb = wdata;
          8'h28: m_rdsz = wdata;  8'h30: m_sctl = wdata;
          8'h34: m_hmask = wdata; 8'h54: m_rmask = wdata;
          8'h58: m_rpol = wdata;  default: ;
        endcase
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, compare against the model
  task automatic step(bit w, logic [7:0] a, logic [31:0] d, logic [16:0] s, logic [7:0] e, bit lm);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ser_in = s; err_in = e; lvl_mode = lm;
    #1;
    check(req_of(a), "rdata", rdata, model_read(a));
    check("R5", "irq_out", {31'h0, irq_out}, {31'h0, m_rstat != 0});
    check("R11", "ext_irq_out", {31'h0, ext_irq_out}, {31'h0, m_lvl != 0});
    check("R11", "lvl_vec", {16'h0, lvl_vec}, {16'h0, m_lvl});
  endtask

  task automatic idle(int n, bit lm = 0);
    for (int i = 0; i < n; i++) step(0, 8'h00, '0, '0, '0, lm);
  endtask

  task automatic peek(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    wr_en = 0; addr = a; ser_in = '0; err_in = '0;
    #1;
    check(req, "peek", rdata, exp);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset values
    peek(8'h28, 32'h0200_0000, "R9");
    peek(8'h50, 32'h0, "R9");
    peek(8'h38, 32'h0, "R9");
    check("R9", "irq_out reset", {31'h0, irq_out}, 32'h0);
    check("R9", "ext reset", {31'h0, ext_irq_out}, 32'h0);
    peek(8'h24, 32'hFFFF_FFFF, "R8");
    peek(8'h31, 32'hFFFF_FFFF, "R8");
    // chain setup
    step(1, 8'h34, 32'h8000_0000, '0, '0, 0);
    step(1, 8'h30, 32'h8000_0000, '0, '0, 0);
    step(1, 8'h54, 32'h0000_0800, '0, '0, 0);
    step(0, 8'h00, '0, 17'h00001, '0, 0);
    idle(4);
    peek(8'h38, 32'h8000_0000, "R1");
    peek(8'h5C, 32'h0000_0800, "R3");
    peek(8'h50, 32'h0000_0800, "R4");
    check("R5", "irq_out set", {31'h0, irq_out}, 32'h1);
    // R2 set wins over clear, then a real clear
    step(1, 8'h38, 32'hFFFF_FFFF, 17'h00001, '0, 0);
    peek(8'h38, 32'h8000_0000, "R2");
    step(1, 8'h38, 32'hFFFF_FFFF, '0, '0, 0);
    peek(8'h38, 32'h0, "R2");
    idle(3);
    peek(8'h5C, 32'h0, "R3");
    peek(8'h50, 32'h0000_0800, "R4");
    step(1, 8'h50, 32'h0000_0800, '0, '0, 0);
    peek(8'h50, 32'h0, "R4");
    check("R5", "irq_out cleared", {31'h0, irq_out}, 32'h0);
    // R6 read-only words
    step(1, 8'h5C, 32'hFFFF_FFFF, '0, '0, 0);
    peek(8'h5C, 32'h0, "R6");
    step(1, 8'h40, 32'h1234_5678, '0, '0, 0);
    peek(8'h40, 32'h0, "R6");
    // R7 store without effect
    step(1, 8'h58, 32'hA5A5_A5A5, '0, '0, 0);
    step(1, 8'h08, 32'hFFFF_FFFF, '0, '0, 0);
    idle(2);
    peek(8'h58, 32'hA5A5_A5A5, "R7");
    check("R7", "irq_out after pol", {31'h0, irq_out}, 32'h0);
    // R8 write to hole ignored
    step(1, 8'h24, 32'h0, '0, '0, 0);
    peek(8'h24, 32'hFFFF_FFFF, "R8");
    // R3 enable gating
    step(1, 8'h30, 32'h0, '0, '0, 0);
    step(0, 8'h00, '0, 17'h00001, '0, 0);
    idle(3);
    peek(8'h38, 32'h8000_0000, "R3");
    peek(8'h5C, 32'h0, "R3");
    // R10 error source
    step(1, 8'h38, 32'hFFFF_FFFF, '0, 8'h08, 0);
    peek(8'h38, 32'h0000_0008, "R10");
    step(1, 8'h38, 32'hFFFF_FFFF, '0, '0, 0);
    // R11 level mode
    step(0, 8'h00, '0, 17'h10020, '0, 1);
    idle(1, 1);
    step(0, 8'h00, '0, '0, '0, 1);
    peek(8'h38, 32'h0, "R11");
    check("R11", "ext after drop", {31'h0, ext_irq_out}, 32'h0);
    step(0, 8'h00, '0, 17'h00004, '0, 1);
    @(negedge clk); #1;
    check("R11", "ext high", {31'h0, ext_irq_out}, 32'h1);
    check("R11", "lvl_vec", {16'h0, lvl_vec}, 32'h4);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] offs [14] = '{8'h08, 8'h0C, 8'h28, 8'h30, 8'h34, 8'h38, 8'h40,
                                8'h50, 8'h54, 8'h58, 8'h5C, 8'h24, 8'h3A, 8'hF0};
      logic [7:0] a = offs[$urandom_range(13)];
      logic [31:0] d = $urandom;
      logic [16:0] s = '0;
      logic [7:0] e = '0;
      for (int b = 0; b < 17; b++) s[b] = ($urandom_range(15) == 0);
      for (int b = 0; b < 8; b++) e[b] = ($urandom_range(31) == 0);
      if (a == 8'h30 && $urandom_range(1)) d[31] = 1'b1;
      step($urandom_range(9) < 3, a, d, s, e, ((i / 500) % 4) == 3);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule